// File: doc/BRIEF.md
# Balanced M-of-N Rail Codec

This block carries a small binary value across a set of rails in a balanced code. Every legal value word has exactly M rails raised, and no legal word fits inside another one. The number of rails N is a parameter, and M defaults to N/2. With N rails the code holds C(N, M) values, so the default of four rails holds six. The encoder side turns an index into a rail word. The decoder side looks at a rail word and reports three things: whether the word is finished, whether it is empty, and which value it holds.

The rail word is captured into a register on every rising clock edge. This models rails that arrive one at a time. A captured word with some rails raised but fewer than M is treated as still arriving and never produces a value. A word with more than M rails raised is illegal. A sequence monitor watches the captured words. It latches an error flag when it sees an illegal word, or when two value words are not separated by an empty (all-clear) word.

Top module: `mofn_codec`

## Requirements
- R1: While reset is held and after it is released with all rails clear, `isNull` is 1 and `complete`, `wordError`, `value` and `seqError` are all 0.
- R2: With `encEn`=1 and `encIdx` below C(N,M), `encRails` is the `encIdx`-th word, counting from zero, in ascending numeric order among all words with exactly M ones. For four rails, indices 0 to 5 give 0011, 0101, 0110, 1001, 1010 and 1100 (bit 3 on the left).
- R3: When `encEn`=0, or when `encIdx` is C(N,M) or above, `encRails` is all zero.
- R4: `railIn` is registered on every rising edge. The decode outputs describe the word captured at the most recent rising edge.
- R5: A captured all-zero word gives `isNull`=1, `complete`=0, `wordError`=0 and `value`=0.
- R6: A captured word with exactly M ones gives `complete`=1, `isNull`=0 and `value` equal to the word's index under the R2 ordering.
- R7: A captured word with between 1 and M-1 ones is incomplete. It gives `complete`=0, `isNull`=0, `wordError`=0 and `value`=0.
- R8: A captured word with more than M ones gives `wordError`=1, `complete`=0 and `value`=0.
- R9: `seqError` becomes 1 one cycle after a word with more than M ones is captured. It then stays 1 until reset.
- R10: `seqError` becomes 1 one cycle after a complete capture that starts a new run of complete captures, if no all-zero capture has occurred since the previous complete capture.
- R11: `seqError` becomes 1 one cycle after a complete capture whose value differs from the complete capture just before it.
- R12: None of these sequences sets `seqError`: one value word held for several captures, a value word followed by a null word and then another value word, or partial words seen while moving from a null word to a value word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous reset, active low |
| encEn | input | 1 | Encoder drives a value word when 1, otherwise a null word |
| encIdx | input | VALW | Value to encode |
| encRails | output | RAILS | Encoded rail word |
| railIn | input | RAILS | Rail word to decode |
| complete | output | 1 | Captured word has exactly M rails raised |
| isNull | output | 1 | Captured word has no rails raised |
| value | output | VALW | Decoded index; 0 unless `complete` is 1 |
| wordError | output | 1 | Captured word has more than M rails raised |
| seqError | output | 1 | Sticky flag for a sequence violation or an illegal word |

## Verification
The sequence rules are the hard part to reach, because any illegal word latches `seqError` for good. Random rail words hit the over-full case within a few samples, so a random run says almost nothing about the null-separation rules. The directed scenarios therefore each begin with a fresh reset. They cover: a held value word, value and null words alternating with partial arrivals in between, two different value words back to back, and a value word that returns after only a partial dip. Random words are then used to stress the classifier and the value ranking against an enumerating model.

// File: rtl/mofn_pkg.sv
package mofn_pkg;

  // Binomial coefficient; zero outside 0 <= k <= n.
  function automatic int binom(input int n, input int k);
    int r;
    if (k < 0 || k > n) return 0;
    r = 1;
    for (int i = 1; i <= k; i++) r = (r * (n - k + i)) / i;
    return r;
  endfunction

  // Strobes passed from the classifier to the sequence monitor.
  typedef struct packed {
    logic complete;
    logic isNull;
    logic overFull;
  } strobe_t;

endpackage

// File: rtl/mofn_datapath.sv
module mofn_datapath #(
  parameter int RAILS = 4,
  parameter int HOT   = RAILS / 2,
  parameter int CODES = mofn_pkg::binom(RAILS, HOT),
  parameter int VALW  = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                encEn,
  input  logic [VALW-1:0]     encIdx,
  output logic [RAILS-1:0]    encRails,
  input  logic [RAILS-1:0]    railIn,
  output logic [VALW-1:0]     value,
  output mofn_pkg::strobe_t   strobes
);
  import mofn_pkg::*;

  logic [RAILS-1:0] railQ;
  logic [RAILS-1:0] encWord;
  int               railCnt;
  int               rankAcc;

  // Rail capture models asynchronous arrival.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) railQ <= '0;
    else       railQ <= railIn;
  end

  // Encoder: unrank index into ascending M-hot word, MSB first.
  always_comb begin
    int left;
    int rem;
    encWord = '0;
    left    = int'(encIdx);
    rem     = HOT;
    for (int p = RAILS - 1; p >= 0; p--) begin
      if (rem > 0 && left >= binom(p, rem)) begin
        encWord[p] = 1'b1;
        left       = left - binom(p, rem);
        rem        = rem - 1;
      end
    end
  end

  assign encRails = (encEn && int'(encIdx) < CODES) ? encWord : '0;

  // Decoder: popcount and rank of captured word.
  always_comb begin
    int rem;
    railCnt = 0;
    rankAcc = 0;
    rem     = HOT;
    for (int p = RAILS - 1; p >= 0; p--) begin
      if (railQ[p]) begin
        railCnt = railCnt + 1;
        rankAcc = rankAcc + binom(p, rem);
        rem     = rem - 1;
      end
    end
  end

  assign strobes.complete = (railCnt == HOT);
  assign strobes.isNull   = (railCnt == 0);
  assign strobes.overFull = (railCnt > HOT);
  assign value            = strobes.complete ? rankAcc[VALW-1:0] : '0;

  // R4
  sample_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> railQ == $past(railIn));

  // R6
  complete_weight_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.complete |-> ($countones(railQ) == HOT && int'(value) < CODES));

  // R7
  value_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.complete |-> value == '0);

  // R2
  enc_weight_chk: assert property (@(posedge clk) disable iff (!rstN)
    (encEn && int'(encIdx) < CODES) |-> $countones(encRails) == HOT);

  // R3
  enc_null_chk: assert property (@(posedge clk) disable iff (!rstN)
    !encEn |-> encRails == '0);

endmodule

// File: rtl/mofn_seqctl.sv
module mofn_seqctl #(
  parameter int VALW = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  mofn_pkg::strobe_t strobes,
  input  logic [VALW-1:0]   value,
  output logic              seqError
);
  logic            needNull;
  logic            prevComplete;
  logic [VALW-1:0] prevValue;
  logic            hit;

  always_comb begin
    hit = strobes.overFull
        | (strobes.complete & needNull & ~prevComplete)
        | (strobes.complete & prevComplete & (value != prevValue));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      needNull     <= 1'b0;
      prevComplete <= 1'b0;
      prevValue    <= '0;
      seqError     <= 1'b0;
    end else begin
      if (strobes.isNull)        needNull <= 1'b0;
      else if (strobes.complete) needNull <= 1'b1;
      prevComplete <= strobes.complete;
      prevValue    <= value;
      seqError     <= seqError | hit;
    end
  end

  // R9
  seq_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqError |=> seqError);

  // R9
  overfull_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.overFull |=> seqError);

  // R11
  value_jump_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.complete && $past(strobes.complete) && value != $past(value)) |=> seqError);

endmodule

// File: rtl/mofn_codec.sv
module mofn_codec #(
  parameter int RAILS = 4,
  parameter int HOT   = RAILS / 2,
  localparam int CODES = mofn_pkg::binom(RAILS, HOT),
  localparam int VALW  = (CODES > 1) ? $clog2(CODES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             encEn,
  input  logic [VALW-1:0]  encIdx,
  output logic [RAILS-1:0] encRails,
  input  logic [RAILS-1:0] railIn,
  output logic             complete,
  output logic             isNull,
  output logic [VALW-1:0]  value,
  output logic             wordError,
  output logic             seqError
);
  mofn_pkg::strobe_t strobes;

  mofn_datapath #(.RAILS(RAILS), .HOT(HOT), .CODES(CODES), .VALW(VALW)) u_dp (
    .clk(clk), .rstN(rstN), .encEn(encEn), .encIdx(encIdx), .encRails(encRails),
    .railIn(railIn), .value(value), .strobes(strobes)
  );

  mofn_seqctl #(.VALW(VALW)) u_ctl (
    .clk(clk), .rstN(rstN), .strobes(strobes), .value(value), .seqError(seqError)
  );

  assign complete  = strobes.complete;
  assign isNull    = strobes.isNull;
  assign wordError = strobes.overFull;

endmodule

// File: tb/sim_mofn_codec.sv
module sim_mofn_codec;
  localparam int RAILS = 4;
  localparam int HOT   = 2;
  localparam int CODES = 6;
  localparam int VALW  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic encEn = 1'b0;
  logic [VALW-1:0] encIdx = '0;
  logic [RAILS-1:0] encRails;
  logic [RAILS-1:0] railIn = '0;
  logic complete, isNull, wordError, seqError;
  logic [VALW-1:0] value;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state for the sequence rules
  bit mNeed, mPc, mSeq;
  int mPv;

  always #10 clk = ~clk;

  mofn_codec #(.RAILS(RAILS), .HOT(HOT)) u0 (
    .clk(clk), .rstN(rstN), .encEn(encEn), .encIdx(encIdx), .encRails(encRails),
    .railIn(railIn), .complete(complete), .isNull(isNull), .value(value),
    .wordError(wordError), .seqError(seqError)
  );

  function automatic int ones(input int w);
    int c = 0;
    for (int i = 0; i < RAILS; i++) c += (w >> i) & 1;
    return c;
  endfunction

  // k-th M-hot word by enumeration; 0 when out of range
  function automatic int expWord(input int k);
    int n = 0;
    for (int w = 0; w < (1 << RAILS); w++) begin
      if (ones(w) == HOT) begin
        if (n == k) return w;
        n++;
      end
    end
    return 0;
  endfunction

  function automatic int expRank(input int w);
    int n = 0;
    for (int u = 0; u < w; u++) if (ones(u) == HOT) n++;
    return n;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    railIn = '0;
    @(negedge clk);
    rstN = 1'b1;
    mNeed = 0; mPc = 0; mSeq = 0; mPv = 0;
  endtask

  // drive one word, check its classification and the flag from prior words
  task automatic step(input int w);
    int c, e, o, n, v;
    bit hit;
    @(negedge clk);
    railIn = w[RAILS-1:0];
    @(negedge clk);
    c = ones(w);
    n = (c == 0);
    e = (c == HOT);
    o = (c > HOT);
    v = e ? expRank(w) : 0;
    chk(isNull == n,     "R5 isNull",     int'(isNull), n);
    chk(complete == e,   "R6 complete",   int'(complete), e);
    chk(wordError == o,  "R8 wordError",  int'(wordError), o);
    chk(int'(value) == v, (c > 0 && c < HOT) ? "R7 value" : "R6 value", int'(value), v);
    chk(seqError == mSeq, "R10 R11 seqError", int'(seqError), int'(mSeq));
    hit = o || (e && mNeed && !mPc) || (e && mPc && v != mPv);
    if (n) mNeed = 0; else if (e) mNeed = 1;
    mPc = e; mPv = v;
    mSeq = mSeq | hit;
  endtask

  task automatic flagIs(input bit exp, input string req);
    @(negedge clk);
    chk(seqError == exp, req, int'(seqError), int'(exp));
  endtask

  initial begin
    void'($urandom(1234));
    mNeed = 0; mPc = 0; mSeq = 0; mPv = 0;
    // R1 during reset
    @(negedge clk);
    chk(isNull == 1'b1 && complete == 1'b0 && wordError == 1'b0 && value == '0 && seqError == 1'b0,
        "R1 reset outputs", int'({isNull, complete, wordError, seqError}), 8);
    rstN = 1'b1;
    @(negedge clk);
    chk(isNull == 1'b1 && seqError == 1'b0, "R1 after release", int'({isNull, seqError}), 2);

    // R2 and R3 encoder sweep
    encEn = 1'b1;
    for (int k = 0; k < (1 << VALW); k++) begin
      encIdx = k[VALW-1:0];
      #1;
      chk(int'(encRails) == expWord(k), k < CODES ? "R2 encode" : "R3 out of range",
          int'(encRails), expWord(k));
    end
    encEn = 1'b0;
    for (int k = 0; k < CODES; k++) begin
      encIdx = k[VALW-1:0];
      #1;
      chk(encRails == '0, "R3 disabled", int'(encRails), 0);
    end

    // R4 latency: word is not visible before the capturing edge
    @(negedge clk);
    railIn = 4'b1010;
    #1;
    chk(isNull == 1'b1, "R4 before edge", int'(isNull), 1);
    @(negedge clk);
    chk(complete == 1'b1 && int'(value) == 4, "R4 after edge", int'(value), 4);

    // R12 legal traffic: hold, null separation, partial arrival
    doReset();
    step(4'b0011); step(4'b0011); step(4'b0011);
    step(4'b0000); step(4'b0100); step(4'b0101);
    step(4'b0001); step(4'b0000); step(4'b1000); step(4'b1100); step(4'b0000);
    flagIs(1'b0, "R12 legal sequence");

    // R10 partial dip without null between value words
    doReset();
    step(4'b0011); step(4'b0001); step(4'b0101); step(4'b0000);
    flagIs(1'b1, "R10 missing null");

    // R10 same value re-arriving after a dip still needs a null
    doReset();
    step(4'b0110); step(4'b0100); step(4'b0110);
    flagIs(1'b1, "R10 same value no null");

    // R11 two different value words back to back
    doReset();
    step(4'b0011); step(4'b1001);
    flagIs(1'b1, "R11 adjacent values");

    // R9 illegal word, then sticky across nulls
    doReset();
    step(4'b0111); step(4'b0000); step(4'b0000);
    flagIs(1'b1, "R9 sticky after illegal");
    doReset();
    step(4'b1111);
    flagIs(1'b1, "R9 full word");

    // random words through the classifier
    doReset();
    for (int i = 0; i < 300; i++) begin
      int w;
      w = $urandom_range(0, (1 << RAILS) - 1);
      if ((i % 3) == 0) w = 0;
      step(w);
    end

    // random encode/decode round trip
    doReset();
    for (int i = 0; i < 100; i++) begin
      int k;
      k = $urandom_range(0, CODES - 1);
      encEn = 1'b1;
      encIdx = k[VALW-1:0];
      #1;
      chk(int'(encRails) == expWord(k), "R2 random encode", int'(encRails), expWord(k));
      step(int'(encRails));
      chk(int'(value) == k, "R6 round trip", int'(value), k);
      step(0);
    end
    encEn = 1'b0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule